// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small processor. It keeps a fixed microprogram in an internal constant control store. Every clock it issues one microinstruction, and each microinstruction drives the control lines of the datapath. A control address register selects a microword. The word is captured in a control buffer register, and the block's outputs come straight from that register. Each microword carries two kinds of control. The first is a set of horizontal bits that go out undecoded. The second is a compact vertical code, which a decoder expands into a one-hot group of lines.

The microword in the buffer also chooses the address of the next microinstruction. There are three sources: the current address plus one, a branch target held in the word, and the start of a microroutine picked from the current instruction opcode. A branch is qualified by a condition selector. The selector reads one ALU flag, or a constant true, or a constant false. The microprogram is a parameter, so a different program can be supplied at instantiation. The default program starts with a fetch microroutine at address 0.

Top module: `ucs_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state after that edge: `car_o` = 0, `horiz_o` = 0 and `vert_lines_o` = 0.
- R2: At the first rising edge with `rst_n` high after a reset, the block issues the microword stored at address 0, and `car_o` stays 0.
- R3: `horiz_o` and the vertical code show the microword held at address `car_o`. The word layout is: bits [21:14] horizontal, [13:11] vertical code, [10:9] next-address mode, [8:6] condition select, [5:0] branch address.
- R4: Mode 0 and mode 3 both step the next address to `car_o` + 1. Address 63 wraps to 0.
- R5: In mode 1, the next address is the branch address field when the selected condition is true, and `car_o` + 1 when it is false.
- R6: Condition select 0 means always true. Select k in 1..4 reads `flags_i[k-1]` in the cycle the word is held. Selects 5 to 7 mean always false.
- R7: Mode 2 jumps to the microroutine start for the opcode present in that cycle, at address 16 + 2 × `opcode_i`.
- R8: A vertical code v in 1..7 raises only `vert_lines_o[v]`. Code 0 raises no line, and `vert_lines_o[0]` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | 4 | Opcode from the instruction register |
| flags_i | input | 4 | ALU status flags |
| horiz_o | output | 8 | Horizontal control lines of the current microword |
| vert_lines_o | output | 8 | One-hot lines decoded from the vertical code |
| car_o | output | 6 | Debug view of the current control address |

## Verification
In a single cycle, the held microword drives its control lines while the same word decides the next address, through the flag-qualified branch or the opcode map. The two results appear together after the next edge: the new address and the lines of the new word. The bench runs a pseudo-random microprogram that mixes all four modes and all eight condition selects. It changes the opcode and the flags every cycle, and adds directed windows with all flags low and all flags high, plus a reset in the middle of a run. After each edge, a bench model derives the expected address and expected lines from the requirements alone, and the bench compares both against the outputs.

// File: rtl/ucs_pkg.sv
// Package: shared definitions for the microprogrammed sequencer.
// Holds the next-address mode encoding, the default field widths, and a
// generator for the default microprogram. That generator assumes the default
// widths (6-bit address, 8 horizontal bits, 3-bit vertical code, 3-bit
// condition select).
package ucs_pkg;

    localparam int DEF_ADDR_W  = 6;
    localparam int DEF_HORIZ_W = 8;
    localparam int DEF_VERT_W  = 3;
    localparam int DEF_COND_W  = 3;
    localparam int DEF_WORD_W  = DEF_HORIZ_W + DEF_VERT_W + 2 + DEF_COND_W + DEF_ADDR_W;
    localparam int DEF_DEPTH   = 2 ** DEF_ADDR_W;

    typedef enum logic [1:0] {
        NA_INC     = 2'd0,
        NA_BRANCH  = 2'd1,
        NA_MAP     = 2'd2,
        NA_INC_ALT = 2'd3
    } nxt_mode_e;

    // Packs one microword in the default layout.
    function automatic logic [DEF_WORD_W-1:0] pack_word(
        logic [DEF_HORIZ_W-1:0] h, logic [DEF_VERT_W-1:0] v, nxt_mode_e m,
        logic [DEF_COND_W-1:0] c, logic [DEF_ADDR_W-1:0] b);
        return {h, v, m, c, b};
    endfunction

    // Builds the default program. Address 0 holds fetch, and address 1
    // dispatches on the opcode. Each routine runs two words and then
    // returns to fetch.
    function automatic logic [DEF_DEPTH*DEF_WORD_W-1:0] default_program();
        logic [DEF_DEPTH*DEF_WORD_W-1:0] prog;
        logic [DEF_WORD_W-1:0] w;
        prog = '0;
        for (int i = 0; i < DEF_DEPTH; i++) begin
            if (i == 0)
                w = pack_word(8'h81, 3'd1, NA_INC, 3'd0, 6'd0);
            else if (i == 1)
                w = pack_word(8'h42, 3'd2, NA_MAP, 3'd0, 6'd0);
            else if (i < 16)
                w = pack_word(8'h00, 3'd0, NA_BRANCH, 3'd0, 6'd0);
            else if ((i % 2) == 0)
                w = pack_word(8'(i), 3'(i % 8), NA_INC, 3'd0, 6'd0);
            else
                w = pack_word(8'(i), 3'd0, NA_BRANCH, 3'd0, 6'd0);
            prog[i*DEF_WORD_W +: DEF_WORD_W] = w;
        end
        return prog;
    endfunction

endpackage

// File: rtl/ucs_store.sv
// Control store: a read-only table of microwords taken from a parameter.
// It is read combinationally, and the caller registers the data.
// Assumes PROGRAM holds DEPTH words of WORD_W bits, with word 0 in the
// least significant bits.
module ucs_store #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 22,
    parameter logic [(2**ADDR_W)*WORD_W-1:0] PROGRAM = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o
);
    // Table lookup by address.
    always_comb word_o = PROGRAM[int'(addr_i)*WORD_W +: WORD_W];
endmodule

// File: rtl/ucs_map.sv
// Opcode mapping decoder: turns an opcode into the start address of its
// microroutine, MAP_BASE + MAP_STRIDE * opcode, truncated to the address
// width. Assumes the routines are laid out at that fixed stride.
module ucs_map #(
    parameter int OPC_W      = 4,
    parameter int ADDR_W     = 6,
    parameter int MAP_BASE   = 16,
    parameter int MAP_STRIDE = 2
) (
    input  logic [OPC_W-1:0]  opcode_i,
    output logic [ADDR_W-1:0] start_o
);
    // Start address arithmetic.
    always_comb start_o = ADDR_W'(MAP_BASE + MAP_STRIDE * int'(opcode_i));
endmodule

// File: rtl/ucs_vdec.sv
// Vertical field decoder: expands a VERT_W-bit code into 2**VERT_W one-hot
// lines. Code 0 means no operation, so line 0 is tied low.
module ucs_vdec #(
    parameter int VERT_W = 3,
    localparam int LINES = 2 ** VERT_W
) (
    input  logic [VERT_W-1:0] code_i,
    output logic [LINES-1:0]  lines_o
);
    assign lines_o[0] = 1'b0;
    for (genvar g = 1; g < LINES; g++) begin : g_line
        assign lines_o[g] = (code_i == VERT_W'(g));
    end
endmodule

// File: rtl/ucs_next_addr.sv
// Next-address selector: picks the increment, the branch field, or the
// opcode-mapped start. The choice follows the mode field and the condition
// select. Select 0 is true, select k in 1..FLAG_W reads flag k-1, and any
// larger select is false. Until the sequencer is primed after reset it
// returns address 0.
module ucs_next_addr
    import ucs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int FLAG_W = 4,
    parameter int COND_W = 3
) (
    input  logic              primed_i,
    input  logic [ADDR_W-1:0] car_i,
    input  nxt_mode_e         mode_i,
    input  logic [COND_W-1:0] cond_sel_i,
    input  logic [ADDR_W-1:0] branch_i,
    input  logic [ADDR_W-1:0] map_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [ADDR_W-1:0] next_o
);
    logic              cond_ok;
    logic [ADDR_W-1:0] step;

    // Condition multiplexer over the constants and the flags.
    always_comb begin
        cond_ok = (int'(cond_sel_i) == 0);
        for (int k = 1; k <= FLAG_W; k++) begin
            if (int'(cond_sel_i) == k) cond_ok = flags_i[k-1];
        end
    end

    assign step = car_i + ADDR_W'(1);

    // Source selection for the next control address.
    always_comb begin
        if (!primed_i) begin
            next_o = '0;
        end else begin
            unique case (mode_i)
                NA_BRANCH: next_o = cond_ok ? branch_i : step;
                NA_MAP:    next_o = map_i;
                default:   next_o = step;
            endcase
        end
    end
endmodule

// File: rtl/ucs_sequencer.sv
// Microprogrammed control sequencer (top). The control address register
// (car_q) and the control buffer register (cbr_q) are loaded together, so
// the buffer always holds the word at address car_q and the outputs follow
// it. Reset is synchronous and active low. After reset the first edge
// fetches address 0.
module ucs_sequencer
    import ucs_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int OPC_W      = 4,
    parameter int FLAG_W     = 4,
    parameter int HORIZ_W    = DEF_HORIZ_W,
    parameter int VERT_W     = DEF_VERT_W,
    parameter int COND_W     = DEF_COND_W,
    parameter int MAP_BASE   = 16,
    parameter int MAP_STRIDE = 2,
    parameter logic [(2**ADDR_W)*(HORIZ_W+VERT_W+2+COND_W+ADDR_W)-1:0] PROGRAM =
        default_program()
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode_i,
    input  logic [FLAG_W-1:0]    flags_i,
    output logic [HORIZ_W-1:0]   horiz_o,
    output logic [2**VERT_W-1:0] vert_lines_o,
    output logic [ADDR_W-1:0]    car_o
);
    localparam int COND_LSB  = ADDR_W;
    localparam int MODE_LSB  = COND_LSB + COND_W;
    localparam int VERT_LSB  = MODE_LSB + 2;
    localparam int HORIZ_LSB = VERT_LSB + VERT_W;
    localparam int WORD_W    = HORIZ_LSB + HORIZ_W;

    logic [ADDR_W-1:0] car_q, next_addr, map_addr;
    logic [WORD_W-1:0] cbr_q, store_word;
    logic              primed_q;

    ucs_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROGRAM(PROGRAM)) store_i (
        .addr_i (next_addr),
        .word_o (store_word)
    );

    ucs_map #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE),
              .MAP_STRIDE(MAP_STRIDE)) map_i (
        .opcode_i (opcode_i),
        .start_o  (map_addr)
    );

    ucs_next_addr #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .COND_W(COND_W)) nxt_i (
        .primed_i   (primed_q),
        .car_i      (car_q),
        .mode_i     (nxt_mode_e'(cbr_q[MODE_LSB +: 2])),
        .cond_sel_i (cbr_q[COND_LSB +: COND_W]),
        .branch_i   (cbr_q[ADDR_W-1:0]),
        .map_i      (map_addr),
        .flags_i    (flags_i),
        .next_o     (next_addr)
    );

    ucs_vdec #(.VERT_W(VERT_W)) vdec_i (
        .code_i  (cbr_q[VERT_LSB +: VERT_W]),
        .lines_o (vert_lines_o)
    );

    // Loads the address and buffer registers together, one microword per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q    <= '0;
            cbr_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            car_q    <= next_addr;
            cbr_q    <= store_word;
            primed_q <= 1'b1;
        end
    end

    assign horiz_o = cbr_q[HORIZ_LSB +: HORIZ_W];
    assign car_o   = car_q;
endmodule

// File: rtl/ucs_sequencer_chk.sv
// Checker for ucs_sequencer: temporal properties on the address register,
// the buffer fields and the decoded outputs. Bound into every instance.
module ucs_sequencer_chk #(
    parameter int ADDR_W     = 6,
    parameter int OPC_W      = 4,
    parameter int FLAG_W     = 4,
    parameter int HORIZ_W    = 8,
    parameter int VERT_W     = 3,
    parameter int COND_W     = 3,
    parameter int MAP_BASE   = 16,
    parameter int MAP_STRIDE = 2,
    parameter int WORD_W     = 22
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [OPC_W-1:0]     opcode,
    input logic [ADDR_W-1:0]    car,
    input logic [WORD_W-1:0]    cbr,
    input logic                 primed,
    input logic [HORIZ_W-1:0]   horiz,
    input logic [2**VERT_W-1:0] vlines
);
    logic [1:0]        mode;
    logic [COND_W-1:0] csel;
    logic [ADDR_W-1:0] baddr;
    assign baddr = cbr[ADDR_W-1:0];
    assign csel  = cbr[ADDR_W +: COND_W];
    assign mode  = cbr[ADDR_W+COND_W +: 2];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (car == '0 && horiz == '0 && vlines == '0 && !primed)); // R1
    AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> (car == '0 && primed)); // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && (mode == 2'd0 || mode == 2'd3)) |=> car == $past(car) + ADDR_W'(1)); // R4
    AST_BRANCH_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && mode == 2'd1 && csel == '0) |=> car == $past(baddr)); // R5
    AST_COND_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && mode == 2'd1 && int'(csel) > FLAG_W) |=> car == $past(car) + ADDR_W'(1)); // R6
    AST_MAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && mode == 2'd2) |=>
        car == ADDR_W'(MAP_BASE + MAP_STRIDE * int'($past(opcode)))); // R7
    AST_VERT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vlines) && !vlines[0]); // R8
endmodule

bind ucs_sequencer ucs_sequencer_chk #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .FLAG_W(FLAG_W), .HORIZ_W(HORIZ_W),
    .VERT_W(VERT_W), .COND_W(COND_W), .MAP_BASE(MAP_BASE),
    .MAP_STRIDE(MAP_STRIDE), .WORD_W(WORD_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode_i), .car(car_q), .cbr(cbr_q),
    .primed(primed_q), .horiz(horiz_o), .vlines(vert_lines_o)
);

// File: tb/ucs_sequencer_tb_top.sv
`timescale 1ns/1ps
// Bench for ucs_sequencer. It loads its own generated microprogram and
// drives random opcodes and flags, plus directed windows. A model built
// from the requirements predicts every output.
module ucs_sequencer_tb_top;
    localparam int WW = 22;
    localparam int NW = 64;

    // Bench microprogram: word i built from arithmetic on i.
    function automatic logic [WW-1:0] tb_word(int i);
        int m;
        logic [1:0] md;
        m  = (i * 7 + 3) % 5;
        md = (m == 0) ? 2'd0 : (m == 1) ? 2'd3 : (m == 4) ? 2'd2 : 2'd1;
        return {8'((i * 29) ^ 8'hA5), 3'((i * 3 + i / 8) % 8), md,
                3'((i * 5 + 1) % 8), 6'((i * 37 + 11) % 64)};
    endfunction

    function automatic logic [NW*WW-1:0] tb_prog();
        logic [NW*WW-1:0] p;
        p = '0;
        for (int i = 0; i < NW; i++) p[i*WW +: WW] = tb_word(i);
        return p;
    endfunction

    localparam logic [NW*WW-1:0] TB_PROG = tb_prog();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode = '0;
    logic [3:0] flags = '0;
    logic [7:0] horiz;
    logic [7:0] vlines;
    logic [5:0] car;

    int checks = 0;
    int errors = 0;
    logic [5:0] m_car = '0;
    bit         m_primed = 1'b0;
    string      car_tag = "R1";

    always #4 clk = ~clk;

    ucs_sequencer #(.PROGRAM(TB_PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .flags_i(flags),
        .horiz_o(horiz), .vert_lines_o(vlines), .car_o(car)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance the model by one edge, using the inputs held at that edge.
    task automatic model_step(bit rst, logic [3:0] opc, logic [3:0] flg);
        logic [WW-1:0] w;
        bit ok;
        if (!rst) begin
            m_car = '0; m_primed = 0; car_tag = "R1";
        end else if (!m_primed) begin
            m_car = '0; m_primed = 1; car_tag = "R2";
        end else begin
            w = tb_word(int'(m_car));
            if (w[8:6] == 3'd0) ok = 1;
            else if (w[8:6] <= 3'd4) ok = flg[w[8:6] - 3'd1];
            else ok = 0;
            case (w[10:9])
                2'd1: begin
                    m_car = ok ? w[5:0] : m_car + 6'd1;
                    car_tag = (w[8:6] == 3'd0) ? "R5" : "R6";
                end
                2'd2: begin m_car = 6'(16 + 2 * int'(opc)); car_tag = "R7"; end
                default: begin m_car = m_car + 6'd1; car_tag = "R4"; end
            endcase
        end
    endtask

    task automatic compare();
        logic [WW-1:0] w;
        logic [7:0] eh, ev;
        w  = tb_word(int'(m_car));
        eh = m_primed ? w[21:14] : 8'h00;
        ev = (m_primed && w[13:11] != 3'd0) ? (8'd1 << w[13:11]) : 8'h00;
        check(car_tag, 32'(car), 32'(m_car));
        check(m_primed ? "R3" : "R1", 32'(horiz), 32'(eh));
        check(m_primed ? "R8" : "R1", 32'(vlines), 32'(ev));
    endtask

    task automatic step(bit rst, logic [3:0] opc, logic [3:0] flg);
        rst_n = rst; opcode = opc; flags = flg;
        @(posedge clk);
        model_step(rst, opc, flg);
        @(negedge clk);
        compare();
    endtask

    initial begin : watchdog
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h1F2E3D4C));
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(0, 4'hF, 4'hF);   // R1 reset holds clear
        step(1, 4'h0, 4'h0);                               // R2 first fetch of word 0
        for (int c = 0; c < 4000; c++) begin
            logic [3:0] o, f;
            o = 4'($urandom);
            f = 4'($urandom);
            if (c >= 1000 && c < 1200) f = 4'h0;           // R6 all conditions false
            if (c >= 1200 && c < 1400) f = 4'hF;           // R6 all conditions true
            if (c >= 1400 && c < 1500) o = (c % 2 == 0) ? 4'h0 : 4'hF; // R7 map extremes
            if (c == 2500 || c == 2501) step(0, o, f);     // R1 mid-run reset
            else step(1, o, f);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule